// File: doc/BRIEF.md
# Radix-4 Distributed-Arithmetic Dot Product

This block computes the signed dot product of a set of tap words with a set of fixed coefficients, and it uses no multiplier to do it. The coefficients are set by parameter when the block is built. Each tap word is consumed two bits at a time, starting at its least significant end. On each working cycle, the bit at the even position of every tap forms the address into one coefficient-sum table. The bit at the odd position forms the address into a second table with the same contents. Each table returns the sum of the coefficients whose address bit is set. The odd result is doubled and combined with the even result. A scaling accumulator then folds this pair sum into the running total and moves its own feedback two bit positions on every step. In the final pair the odd bit is the sign bit of the word, so its contribution is subtracted.

The tap words enter through a valid/ready port. The sample width W must be even. A word set is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result has been delivered, so the source must hold back. The result leaves through a valid/ready port. `out_valid` rises W/2 cycles after acceptance. The result stays held until the sink raises `out_ready`. The result is kept at full precision, W+CW+ceil(log2 NTAPS) bits.

Top module: `da4_mac`

## Requirements
- R1: While reset is applied and on the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: `out_result` equals the exact signed sum over all taps i of tap_i × coef_i. Tap i occupies bits [i·W +: W] of `in_taps` and coefficient i occupies bits [i·CW +: CW] of `COEFS`, and both are two's complement.
- R3: `out_valid` rises exactly W/2 clock cycles after the edge that accepts the input.
- R4: After an input is accepted, `in_ready` stays 0 until the result has been taken. Any `in_valid` or `in_taps` activity in that window has no effect on the result being computed.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_result` does not change.
- R6: The sign bit of each tap is weighted negatively. Taps at the most negative value (-2^(W-1)) and at the most positive value both give the exact product sum.
- R7: On the cycle after `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.
- R8: When exactly one tap is nonzero, the result is that tap times its own coefficient alone. This shows that each table address bit selects only its own coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Tap word set is offered |
| in_ready | output | 1 | Block can accept a tap word set |
| in_taps | input | NTAPS·W | Packed signed tap words, tap 0 in the low bits |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Sink takes the result |
| out_result | output | W+CW+clog2(NTAPS) | Full-precision signed dot product |

## Verification
The bench aims at the sign pair. It sends taps at the most negative and most positive values. A design that added the top odd-table term instead of subtracting it would be off by a multiple of 2^W on every negative tap. Single-tap impulses expose a table that sums the wrong coefficients or swaps the even and odd tables. The bench measures latency against the accept edge, so an off-by-one in the step counter shows up as a rise at W/2±1. It also withholds `out_ready` at random, so a result that moves or a valid that drops while the output is stalled gets caught. Garbage taps are driven during the busy window, so a block that reloaded its slicer would return a wrong sum.

// File: rtl/da4_pkg.sv
package da4_pkg;

  // Sequencer states of the radix-4 engine
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } da4_state_e;

  // Width of a sum of n signed words of width w
  function automatic int sum_width(input int w, input int n);
    return w + $clog2(n);
  endfunction

endpackage

// File: rtl/da4_coef_lut.sv
// Coefficient-sum table: returns the sum of every coefficient whose
// address bit is set. Built as an adder network from the parameter.
module da4_coef_lut #(
  parameter int NTAPS = 4,
  parameter int CW    = 8,
  parameter int LW    = 10,
  parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
  input  logic [NTAPS-1:0]     addr,
  output logic signed [LW-1:0] sum
);

  logic signed [LW-1:0] coef_ext [NTAPS];

  for (genvar i = 0; i < NTAPS; i++) begin : g_ext
    assign coef_ext[i] = LW'($signed(COEFS[i*CW +: CW]));
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NTAPS; i++) begin
      if (addr[i]) sum = sum + coef_ext[i];
    end
  end

endmodule

// File: rtl/da4_bit_slicer.sv
// Holds the accepted tap words and presents two bit planes per step.
module da4_bit_slicer #(
  parameter int NTAPS = 4,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [NTAPS*W-1:0] taps_in,
  output logic [NTAPS-1:0]   even_addr,
  output logic [NTAPS-1:0]   odd_addr
);

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    logic [W-1:0] word;

    always_ff @(posedge clk) begin
      if (!rst_n)     word <= '0;
      else if (load)  word <= taps_in[i*W +: W];
      else if (shift) word <= word >> 2;
    end

    assign even_addr[i] = word[0];
    assign odd_addr[i]  = word[1];
  end

endmodule

// File: rtl/da4_scale_acc.sv
// Scaling accumulator: feedback moves two places right each step while
// the new pair term enters at the top weight, so the sum stays exact.
module da4_scale_acc #(
  parameter int LW = 10,
  parameter int W  = 8,
  parameter int AW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  input  logic                 last,
  input  logic signed [LW-1:0] even_sum,
  input  logic signed [LW-1:0] odd_sum,
  output logic signed [AW-1:0] acc
);

  localparam int PW = LW + 2;

  logic signed [PW-1:0] even_w, odd_w, pair;
  logic signed [AW-1:0] term;

  always_comb begin
    even_w = PW'(even_sum);
    odd_w  = PW'(odd_sum) <<< 1;
    pair   = last ? (even_w - odd_w) : (even_w + odd_w);
    term   = AW'(pair) <<< (W - 2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) acc <= '0;
    else if (step)       acc <= (acc >>> 2) + term;
  end

endmodule

// File: rtl/da4_ctrl.sv
// Sequencer: accept, W/2 working steps, hold until the sink takes it.
module da4_ctrl
  import da4_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic step,
  output logic last
);

  localparam int CNTW = (STEPS > 1) ? $clog2(STEPS) : 1;

  da4_state_e      state, state_n;
  logic [CNTW-1:0] cnt, cnt_n;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign load      = in_valid && in_ready;
  assign step      = (state == ST_RUN);
  assign last      = step && (cnt == CNTW'(STEPS - 1));

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    unique case (state)
      ST_IDLE: begin
        cnt_n = '0;
        if (load) state_n = ST_RUN;
      end
      ST_RUN: begin
        cnt_n = cnt + 1'b1;
        if (last) state_n = ST_HOLD;
      end
      ST_HOLD: begin
        if (out_ready) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

endmodule

// File: rtl/da4_mac.sv
// Radix-4 distributed-arithmetic dot product, valid/ready at both ends.
module da4_mac
  import da4_pkg::*;
#(
  parameter int NTAPS = 4,
  parameter int W     = 8,
  parameter int CW    = 8,
  parameter logic [NTAPS*CW-1:0] COEFS = 32'h807F_9C25,
  localparam int RW   = W + CW + $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NTAPS*W-1:0]   in_taps,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [RW-1:0] out_result
);

  localparam int LW    = sum_width(CW, NTAPS);
  localparam int STEPS = W / 2;
  localparam int LANES = 2;

  logic load, step, last;
  logic [NTAPS-1:0]     addr [LANES];
  logic signed [LW-1:0] lsum [LANES];

  da4_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .step      (step),
    .last      (last)
  );

  da4_bit_slicer #(.NTAPS(NTAPS), .W(W)) u_slicer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .shift     (step),
    .taps_in   (in_taps),
    .even_addr (addr[0]),
    .odd_addr  (addr[1])
  );

  // Two identical tables: lane 0 for even bits, lane 1 for odd bits
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    da4_coef_lut #(.NTAPS(NTAPS), .CW(CW), .LW(LW), .COEFS(COEFS)) u_lut (
      .addr (addr[l]),
      .sum  (lsum[l])
    );
  end

  da4_scale_acc #(.LW(LW), .W(W), .AW(RW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load),
    .step     (step),
    .last     (last),
    .even_sum (lsum[0]),
    .odd_sum  (lsum[1]),
    .acc      (out_result)
  );

endmodule

// File: rtl/da4_mac_chk.sv
module da4_mac_chk #(
  parameter int NTAPS = 4,
  parameter int W     = 8,
  parameter int CW    = 8,
  localparam int RW   = W + CW + $clog2(NTAPS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [RW-1:0] out_result
);

  localparam int STEPS = W / 2;
  localparam int CNTW  = $clog2(STEPS + 2) + 1;

  logic [CNTW-1:0] since_acc;

  always_ff @(posedge clk) begin
    if (!rst_n)                        since_acc <= '0;
    else if (in_valid && in_ready)     since_acc <= CNTW'(1);
    else if (out_valid && out_ready)   since_acc <= '0;
    else if (since_acc != '0 && !out_valid) since_acc <= since_acc + 1'b1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> since_acc == CNTW'(STEPS + 1));

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R7
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

endmodule

bind da4_mac da4_mac_chk #(.NTAPS(NTAPS), .W(W), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/da4_mac_test.sv
module da4_mac_test;

  localparam int NTAPS = 4;
  localparam int W     = 8;
  localparam int CW    = 8;
  localparam logic [NTAPS*CW-1:0] COEFS = {8'h80, 8'h7F, 8'h9C, 8'h25};
  localparam int RW    = W + CW + $clog2(NTAPS);
  localparam int STEPS = W / 2;

  typedef struct {
    longint exp;
    int     acc_cyc;
    string  tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NTAPS*W-1:0] in_taps = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [RW-1:0] out_result;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int sent = 0;
  int got = 0;
  bit finished = 1'b0;
  item_t sb [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  da4_mac #(.NTAPS(NTAPS), .W(W), .CW(CW), .COEFS(COEFS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_taps(in_taps), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result)
  );

  function automatic longint ref_dot(input logic [NTAPS*W-1:0] t);
    longint s = 0;
    for (int i = 0; i < NTAPS; i++)
      s += longint'($signed(t[i*W +: W])) * longint'($signed(COEFS[i*CW +: CW]));
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [NTAPS*W-1:0] t, input string tag);
    item_t it;
    @(negedge clk);
    in_taps  = t;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    it.exp = ref_dot(t);
    it.acc_cyc = cyc + 1;
    it.tag = tag;
    sb.push_back(it);
    sent++;
    @(negedge clk);
    // R4: busy, garbage offered must be refused and ignored
    check(in_ready == 1'b0, "R4 in_ready while busy", longint'(in_ready), 0);
    in_taps = {$urandom, $urandom};
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    bit prev_v = 1'b0;
    bit stalled = 1'b0;
    bit released = 1'b0;
    logic signed [RW-1:0] held = '0;
    item_t it;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (released) begin
        // R7
        check(in_ready && !out_valid, "R7 idle after take",
              longint'({in_ready, out_valid}), 2);
        released = 1'b0;
      end
      if (stalled) begin
        // R5
        check(out_valid && out_result == held, "R5 hold under stall",
              longint'(out_result), longint'(held));
        stalled = 1'b0;
      end
      out_ready = ($urandom % 4) != 0;
      if (out_valid && !prev_v && sb.size() != 0) begin
        // R3
        check(cyc == sb[0].acc_cyc + STEPS, "R3 latency",
              longint'(cyc - sb[0].acc_cyc), STEPS);
      end
      prev_v = out_valid;
      if (out_valid && !out_ready) begin
        stalled = 1'b1;
        held = out_result;
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected result", longint'(out_result), 0);
        end else begin
          it = sb.pop_front();
          check(longint'(out_result) == it.exp, it.tag, longint'(out_result), it.exp);
        end
        got++;
        released = 1'b1;
        prev_v = 1'b0;
      end
    end
  end

  // Driver
  initial begin
    logic [NTAPS*W-1:0] t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check(in_ready && !out_valid, "R1 reset state", longint'({in_ready, out_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R1 after reset", longint'({in_ready, out_valid}), 2);

    send('0, "R2 all zero");
    send({NTAPS{8'h80}}, "R6 all most negative");
    send({NTAPS{8'h7F}}, "R6 all most positive");
    send({8'h7F, 8'h80, 8'h7F, 8'h80}, "R6 alternating extremes");
    send({NTAPS{8'hFF}}, "R6 all minus one");
    for (int i = 0; i < NTAPS; i++) begin
      t = '0;
      t[i*W +: W] = 8'h01;
      send(t, "R8 unit impulse");
      t[i*W +: W] = 8'h80;
      send(t, "R8 negative impulse");
      t[i*W +: W] = 8'hAA;
      send(t, "R8 odd-bit impulse");
    end
    for (int n = 0; n < 300; n++) begin
      t = {$urandom, $urandom};
      send(t, "R2 random");
    end
    while (got < sent) @(negedge clk);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", got, sent);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule